// File: doc/BRIEF.md
# Audio DMA Stream Register File

This block keeps the bus-master registers of one audio DMA stream and makes them reachable through a synchronous register port that works on 32-bit words with a byte-enable field. A single access can therefore touch one byte, a 16-bit half or a whole word. The registers are a descriptor-list base address, a current descriptor index, a last valid index, a 16-bit status word, a remaining-sample count, a prefetched index and an 8-bit control byte.

The memory transfers and the descriptor fetches are done by a neighbouring sequencer, which is outside this block. The sequencer sees the run state, the base address and the last valid index on output ports. It gets a one-cycle fetch request whenever the stream is started. It sends results back through a load strobe and through status set and clear masks.

Status bits come in three kinds: read-only, write-one-to-clear and sticky. The three interrupt causes each have an enable bit in control, and they combine into a single registered interrupt line.

Top module: `audio_dma_regfile`

Register port layout. The word index `req_dw` selects one 32-bit word, and byte lane n is bits 8n+7:8n of that word.

| Word | Lane 0 | Lane 1 | Lanes 2-3 |
|------|--------|--------|-----------|
| 0 | base address [7:0] | base address [15:8] | base address [31:16] |
| 1 | current index | last valid index | status [15:0] |
| 2 | count [7:0] | count [15:8] | lane 2: prefetched index, lane 3: control |
| 3 | zero | zero | zero |

Status bits:
- bit 0: halted (read-only)
- bit 1: at-last-buffer (read-only)
- bit 2: last-buffer interrupt (write-one-to-clear)
- bit 3: buffer-complete interrupt (write-one-to-clear)
- bit 4: FIFO-error interrupt (write-one-to-clear)
- bits 12:8: sticky flags
- all other bits are read-only

Control bits:
- bit 0: run
- bit 1: stream reset (self-clearing)
- bit 2: last-buffer interrupt enable
- bit 3: buffer-complete interrupt enable
- bit 4: FIFO-error interrupt enable
- bits 7:5: always read zero

## Requirements
- R1: After reset, status reads 0x0001 (halted), and every other register, `irq`, `run`, `bd_valid` and `fetch_req` are zero.
- R2: A write to word 0 updates only the byte lanes whose enable is set. Base address bits 1:0 always store zero.
- R3: A write to lane 1 of word 1 stores the written byte modulo NDESC (32) as the last valid index. Bus writes to the current index, count and prefetched index lanes leave those registers unchanged.
- R4: A status write sets those of bits 12:8 that are written as 1. Writing 0 never clears them, and bits 1:0, 7:5 and 15:13 are not changed by bus writes.
- R5: Each of status bits 4:2 is cleared by a bus write with a 1 in its position. A 0 in its position leaves it unchanged.
- R6: `irq` is re-evaluated only in a cycle where status bits 4:2 change. It then becomes 1 exactly when some set cause bit has its enable in control (status bit k pairs with control bit k, for k = 2..4). A change of the enables alone does not alter `irq`.
- R7: When status bits 4:2 all become zero, `irq` drops.
- R8: Word 1 reads as {status, last valid index, current index} and word 2 as {control, prefetched index, count}. Lanes that are not enabled read zero, so a one-lane read of lane 2 in word 1 returns only the status low byte.
- R9: Read data appears on `rsp_rdata` after the clock edge that samples the read request, and holds until the next read.
- R10: A control write stores the value masked to 0x1D. When run goes from 0 to 1, halted clears and `fetch_req` is high for exactly the next cycle. When run goes from 1 to 0, halted sets.
- R11: The sequencer's `seq_sts_set`/`seq_sts_clr` masks reach every status bit, including read-only ones. Such updates pass through the same interrupt evaluation, so a fetch completion that sets bit 3 with its enable on raises `irq`.
- R12: Writing control with bit 1 set resets the stream. Base address, current, last valid and prefetched indices, count and `bd_valid` all clear, control keeps only bits 4:2, run clears and halted sets.
- R13: A `seq_load` pulse loads the current index, prefetched index and count from the sequencer and sets `bd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw | input | 2 | Word index |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| seq_load | input | 1 | Load indices and count from the sequencer |
| seq_civ | input | IDX_W | Current index to load |
| seq_piv | input | IDX_W | Prefetched index to load |
| seq_cnt | input | CNT_W | Sample count to load |
| seq_sts_set | input | 16 | Status bits set by the sequencer |
| seq_sts_clr | input | 16 | Status bits cleared by the sequencer |
| base_addr | output | 32 | Descriptor-list base address |
| last_idx | output | IDX_W | Last valid index |
| run | output | 1 | Control run bit |
| halted | output | 1 | Status halted bit |
| bd_valid | output | 1 | Descriptor loaded and valid |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| irq | output | 1 | Interrupt request |

## Verification
A write, a sequencer strobe or a status change is sampled at one rising edge. The register, `halted`, `irq` and `fetch_req` show the new value right after that same edge, and `fetch_req` is low again one cycle later. Read data lands on `rsp_rdata` one edge after the read request. The bench drives every request on a falling edge and removes it on the next falling edge, then samples the outputs at that point, which falls between the edge that took the request and the next one. The enables, control values, last-index values and lane masks are swept, and each expected word is computed from the requirement's layout.

// File: rtl/adr_pkg.sv
// Shared constants for the audio DMA stream register file: word indices,
// status bit classes and control bit positions.
package adr_pkg;
    localparam logic [1:0]  DW_BASE      = 2'd0;
    localparam logic [1:0]  DW_IDX       = 2'd1;
    localparam logic [1:0]  DW_CNT       = 2'd2;

    localparam int          ST_HALT      = 0;
    localparam int          INT_LO       = 2;
    localparam int          INT_W        = 3;
    localparam logic [15:0] STS_SET_MASK = 16'h1F00;
    localparam logic [15:0] STS_W1C_MASK = 16'h001C;
    localparam logic [15:0] STS_RESET    = 16'h0001;

    localparam int          CR_RUN       = 0;
    localparam int          CR_SRST      = 1;
    localparam logic [7:0]  CR_VALID     = 8'h1D;
    localparam logic [7:0]  CR_KEEP      = 8'h1C;
endpackage

// File: rtl/adr_ctrl.sv
// Control byte of the stream. It decodes run edges and the self-clearing
// stream reset, and pulses the fetch request after a start.
// Assumes at most one control write per cycle.
module adr_ctrl
    import adr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output logic [7:0] ctrl_q,
    output logic       run_rise,
    output logic       halt_req,
    output logic       srst,
    output logic       fetch_req
);
    logic [7:0] nxt;

    // Decode the requested control value and the run transitions.
    always_comb begin
        srst     = wr_en & wbyte[CR_SRST];
        nxt      = wbyte & CR_VALID;
        run_rise = wr_en & ~srst & nxt[CR_RUN] & ~ctrl_q[CR_RUN];
        halt_req = srst | (wr_en & ~nxt[CR_RUN] & ctrl_q[CR_RUN]);
    end

    // Hold the control byte and the one-cycle fetch request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            fetch_req <= 1'b0;
        end else begin
            fetch_req <= run_rise;
            if (wr_en) begin
                ctrl_q <= srst ? (ctrl_q & CR_KEEP) : nxt;
            end
        end
    end
endmodule

// File: rtl/adr_status.sv
// Status word and interrupt line. Sequencer set/clear masks are applied
// first, then bus writes (sticky set, write-one-to-clear), then the run
// transitions. The interrupt is re-evaluated only when the cause bits change.
module adr_status
    import adr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lane_we,
    input  logic [15:0]       wdata,
    input  logic [15:0]       seq_set,
    input  logic [15:0]       seq_clr,
    input  logic              run_rise,
    input  logic              halt_req,
    input  logic [INT_W-1:0]  int_en,
    output logic [15:0]       sts_q,
    output logic              irq
);
    logic [15:0] wval;
    logic [15:0] s_nxt;

    // Merge every source of change into the next status value.
    always_comb begin
        wval  = {lane_we[1] ? wdata[15:8] : 8'h00, lane_we[0] ? wdata[7:0] : 8'h00};
        s_nxt = (sts_q | seq_set) & ~seq_clr;
        s_nxt = s_nxt | (wval & STS_SET_MASK);
        s_nxt = s_nxt & ~(wval & STS_W1C_MASK);
        if (run_rise) s_nxt[ST_HALT] = 1'b0;
        if (halt_req) s_nxt[ST_HALT] = 1'b1;
    end

    // Register status and evaluate the interrupt on cause changes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= STS_RESET;
            irq   <= 1'b0;
        end else begin
            sts_q <= s_nxt;
            if (s_nxt[INT_LO +: INT_W] != sts_q[INT_LO +: INT_W]) begin
                irq <= |(s_nxt[INT_LO +: INT_W] & int_en);
            end
        end
    end
endmodule

// File: rtl/adr_index.sv
// Base address, indices, sample count and descriptor-valid flag.
// The base address is written per byte lane and its low two bits are
// forced to zero. Stream reset has priority over every other update.
module adr_index #(
    parameter  int NDESC = 32,
    parameter  int CNT_W = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       base_we,
    input  logic [31:0]      wdata,
    input  logic             lvi_we,
    input  logic             srst,
    input  logic             seq_load,
    input  logic [IDX_W-1:0] seq_civ,
    input  logic [IDX_W-1:0] seq_piv,
    input  logic [CNT_W-1:0] seq_cnt,
    output logic [31:0]      base_q,
    output logic [IDX_W-1:0] civ_q,
    output logic [IDX_W-1:0] lvi_q,
    output logic [IDX_W-1:0] piv_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             bd_valid
);
    for (genvar l = 0; l < 4; l++) begin : g_lane
        localparam logic [7:0] KEEP = (l == 0) ? 8'hFC : 8'hFF;
        logic [7:0] q;
        // One byte lane of the base address.
        always_ff @(posedge clk) begin
            if (!rst_n || srst) q <= '0;
            else if (base_we[l]) q <= wdata[8*l +: 8] & KEEP;
        end
        assign base_q[8*l +: 8] = q;
    end

    // Indices, count and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            civ_q    <= '0;
            lvi_q    <= '0;
            piv_q    <= '0;
            cnt_q    <= '0;
            bd_valid <= 1'b0;
        end else begin
            if (lvi_we) lvi_q <= IDX_W'(32'(wdata[15:8]) % NDESC);
            if (seq_load) begin
                civ_q    <= seq_civ;
                piv_q    <= seq_piv;
                cnt_q    <= seq_cnt;
                bd_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adr_readmux.sv
// Packs the narrow registers into 32-bit words, masks out the disabled
// byte lanes and registers the result. Holds its value between reads.
module adr_readmux
    import adr_pkg::*;
#(
    parameter  int NDESC = 32,
    parameter  int CNT_W = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       dw,
    input  logic [3:0]       be,
    input  logic [31:0]      base_q,
    input  logic [IDX_W-1:0] civ_q,
    input  logic [IDX_W-1:0] lvi_q,
    input  logic [IDX_W-1:0] piv_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [15:0]      sts_q,
    input  logic [7:0]       ctrl_q,
    output logic [31:0]      rdata
);
    logic [31:0] word;
    logic [31:0] mask;

    for (genvar l = 0; l < 4; l++) begin : g_mask
        assign mask[8*l +: 8] = {8{be[l]}};
    end

    // Select and pack the addressed word.
    always_comb begin
        case (dw)
            DW_BASE: word = base_q;
            DW_IDX:  word = {sts_q, 8'(lvi_q), 8'(civ_q)};
            DW_CNT:  word = {ctrl_q, 8'(piv_q), 16'(cnt_q)};
            default: word = '0;
        endcase
    end

    // Register the lane-masked read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) rdata <= word & mask;
    end
endmodule

// File: rtl/audio_dma_regfile.sv
// Top of the audio DMA stream register file. It decodes the register
// port into lane strobes and connects control, status, index and read
// logic. Assumes the sequencer drives its strobes synchronously to clk.
module audio_dma_regfile
    import adr_pkg::*;
#(
    parameter  int NDESC = 32,
    parameter  int CNT_W = 16,
    localparam int IDX_W = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_dw,
    input  logic [3:0]       req_be,
    input  logic [31:0]      req_wdata,
    output logic [31:0]      rsp_rdata,
    input  logic             seq_load,
    input  logic [IDX_W-1:0] seq_civ,
    input  logic [IDX_W-1:0] seq_piv,
    input  logic [CNT_W-1:0] seq_cnt,
    input  logic [15:0]      seq_sts_set,
    input  logic [15:0]      seq_sts_clr,
    output logic [31:0]      base_addr,
    output logic [IDX_W-1:0] last_idx,
    output logic             run,
    output logic             halted,
    output logic             bd_valid,
    output logic             fetch_req,
    output logic             irq
);
    logic             wr, rd;
    logic [3:0]       base_we;
    logic             lvi_we, ctrl_we;
    logic [1:0]       sts_lane;
    logic [7:0]       ctrl_q;
    logic             run_rise, halt_req, srst_pulse;
    logic [15:0]      sts_q;
    logic [IDX_W-1:0] civ_q, piv_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode the register port into per-register lane strobes.
    always_comb begin
        wr       = req_valid & req_write;
        rd       = req_valid & ~req_write;
        base_we  = {4{wr && req_dw == DW_BASE}} & req_be;
        lvi_we   = wr && req_dw == DW_IDX && req_be[1];
        sts_lane = {2{wr && req_dw == DW_IDX}} & req_be[3:2];
        ctrl_we  = wr && req_dw == DW_CNT && req_be[3];
    end

    adr_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wbyte(req_wdata[31:24]),
        .ctrl_q(ctrl_q), .run_rise(run_rise), .halt_req(halt_req),
        .srst(srst_pulse), .fetch_req(fetch_req)
    );

    adr_status sts_i (
        .clk(clk), .rst_n(rst_n), .lane_we(sts_lane), .wdata(req_wdata[31:16]),
        .seq_set(seq_sts_set), .seq_clr(seq_sts_clr), .run_rise(run_rise),
        .halt_req(halt_req), .int_en(ctrl_q[INT_LO +: INT_W]),
        .sts_q(sts_q), .irq(irq)
    );

    adr_index #(.NDESC(NDESC), .CNT_W(CNT_W)) idx_i (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .wdata(req_wdata),
        .lvi_we(lvi_we), .srst(srst_pulse), .seq_load(seq_load),
        .seq_civ(seq_civ), .seq_piv(seq_piv), .seq_cnt(seq_cnt),
        .base_q(base_addr), .civ_q(civ_q), .lvi_q(last_idx), .piv_q(piv_q),
        .cnt_q(cnt_q), .bd_valid(bd_valid)
    );

    adr_readmux #(.NDESC(NDESC), .CNT_W(CNT_W)) rmux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd), .dw(req_dw), .be(req_be),
        .base_q(base_addr), .civ_q(civ_q), .lvi_q(last_idx), .piv_q(piv_q),
        .cnt_q(cnt_q), .sts_q(sts_q), .ctrl_q(ctrl_q), .rdata(rsp_rdata)
    );

    assign run    = ctrl_q[CR_RUN];
    assign halted = sts_q[ST_HALT];
endmodule

// File: rtl/adr_checker.sv
// Temporal checks on the stream register file, attached by bind.
module adr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        halted,
    input logic        fetch_req,
    input logic        irq,
    input logic [2:0]  int_bits,
    input logic        srst,
    input logic [31:0] base_addr,
    input logic        bd_valid
);
    AST_FETCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> fetch_req); // R10
    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req); // R10
    AST_HALT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> halted); // R10
    AST_IRQ_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != $past(irq)) |-> (int_bits != $past(int_bits))); // R6
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_bits != 3'b000)); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (base_addr == 32'h0 && !bd_valid && !run && halted)); // R12
endmodule

bind audio_dma_regfile adr_checker chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .halted(halted),
    .fetch_req(fetch_req), .irq(irq), .int_bits(sts_q[4:2]),
    .srst(srst_pulse), .base_addr(base_addr), .bd_valid(bd_valid)
);

// File: tb/audio_dma_regfile_tb_top.sv
// Self-checking bench: sweeps lane masks, index values, status write
// patterns, interrupt enables and control values, with expected values
// computed from the register layout.
module audio_dma_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_dw = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        seq_load = 1'b0;
    logic [4:0]  seq_civ = '0, seq_piv = '0;
    logic [15:0] seq_cnt = '0, seq_sts_set = '0, seq_sts_clr = '0;
    logic [31:0] base_addr;
    logic [4:0]  last_idx;
    logic        run, halted, bd_valid, fetch_req, irq;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] exp_sts;
    logic [7:0]  exp_ctrl;
    logic [31:0] rd;

    always #10 clk = ~clk;

    audio_dma_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dw(req_dw), .req_be(req_be), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .seq_load(seq_load), .seq_civ(seq_civ), .seq_piv(seq_piv), .seq_cnt(seq_cnt),
        .seq_sts_set(seq_sts_set), .seq_sts_clr(seq_sts_clr), .base_addr(base_addr),
        .last_idx(last_idx), .run(run), .halted(halted), .bd_valid(bd_valid),
        .fetch_req(fetch_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dw = dw; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] dw, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = dw; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic seq_pulse(input logic [15:0] s, input logic [15:0] c);
        @(negedge clk);
        seq_sts_set = s; seq_sts_clr = c;
        @(negedge clk);
        seq_sts_set = '0; seq_sts_clr = '0;
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
        return m;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_sts = 16'h0001;
        exp_ctrl = 8'h00;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 run", {31'b0, run}, 32'h0);
        chk("R1 halted", {31'b0, halted}, 32'h1);
        chk("R1 bd_valid", {31'b0, bd_valid}, 32'h0);
        chk("R1 fetch_req", {31'b0, fetch_req}, 32'h0);
        bus_read(2'd0, 4'hF, rd); chk("R1 word0", rd, 32'h0);
        bus_read(2'd1, 4'hF, rd); chk("R1 word1", rd, 32'h0001_0000);
        bus_read(2'd2, 4'hF, rd); chk("R1 word2", rd, 32'h0);
        bus_read(2'd3, 4'hF, rd); chk("R1 word3", rd, 32'h0);

        // R2: byte-lane merge and alignment of the base address
        for (int be = 0; be < 16; be++) begin
            logic [31:0] d, m, e;
            d = 32'h1F2E3D4F + be * 32'h01010101;
            m = lane_mask(4'(be));
            bus_write(2'd0, 4'hF, 32'hFFFF_FFFF);
            bus_write(2'd0, 4'(be), d);
            e = ((d & m) | (32'hFFFF_FFFF & ~m)) & 32'hFFFF_FFFC;
            chk("R2 base port", base_addr, e);
            bus_read(2'd0, 4'hF, rd); chk("R2 base read", rd, e);
        end

        // R3: last valid index modulo 32
        for (int v = 0; v < 256; v++) begin
            bus_write(2'd1, 4'b0010, 32'(v) << 8);
            chk("R3 last_idx", {27'b0, last_idx}, 32'(v % 32));
        end
        bus_write(2'd1, 4'b0001, 32'hFF);
        bus_write(2'd2, 4'b0111, 32'h00FF_FFFF);
        bus_read(2'd1, 4'b0001, rd); chk("R3 civ not writable", rd, 32'h0);
        bus_read(2'd2, 4'b0111, rd); chk("R3 cnt/piv not writable", rd, 32'h0);

        // R13: sequencer load
        @(negedge clk);
        seq_load = 1'b1; seq_civ = 5'd5; seq_piv = 5'd6; seq_cnt = 16'h1234;
        @(negedge clk);
        seq_load = 1'b0;
        chk("R13 bd_valid", {31'b0, bd_valid}, 32'h1);
        bus_read(2'd1, 4'b0001, rd); chk("R13 civ", rd, 32'h05);
        bus_read(2'd2, 4'b0111, rd); chk("R13 piv/cnt", rd, 32'h0006_1234);

        // R8: dword packing
        bus_write(2'd1, 4'b0010, 32'h0000_1100);
        bus_write(2'd2, 4'b1000, 32'h1C00_0000);
        bus_read(2'd1, 4'hF, rd); chk("R8 word1 pack", rd, {exp_sts, 8'h11, 8'h05});
        bus_read(2'd2, 4'hF, rd); chk("R8 word2 pack", rd, 32'h1C06_1234);
        bus_write(2'd2, 4'b1000, 32'h0);

        // R9: read data arrives after the edge and holds
        bus_read(2'd2, 4'b0011, rd); chk("R9 read data", rd, 32'h0000_1234);
        @(negedge clk); chk("R9 hold", rsp_rdata, 32'h0000_1234);

        // R4/R5: status write sweep (enables off, irq must stay low)
        for (int k = 0; k < 32; k++) begin
            logic [15:0] w;
            w = {3'b000, 5'(k), 3'b000, 5'(k)};
            seq_pulse(16'h001C, 16'h0);
            exp_sts = exp_sts | 16'h001C;
            bus_write(2'd1, 4'b1100, {w, 16'h0});
            exp_sts = (exp_sts | (w & 16'h1F00)) & ~(w & 16'h001C);
            bus_read(2'd1, 4'b1100, rd); chk("R4 R5 status word", rd, {exp_sts, 16'h0});
            chk("R6 irq disabled", {31'b0, irq}, 32'h0);
        end
        bus_write(2'd1, 4'b1100, 32'h0);
        bus_read(2'd1, 4'b1100, rd); chk("R4 sticky kept on zero write", rd, {exp_sts, 16'h0});
        bus_read(2'd1, 4'b0100, rd); chk("R8 byte read status", rd, {8'h0, exp_sts[7:0], 16'h0});

        // R6/R7: enables vs causes sweep
        for (int en = 0; en < 8; en++) begin
            bus_write(2'd2, 4'b1000, 32'(en) << 26);
            for (int b = 0; b < 3; b++) begin
                seq_pulse(16'(1 << (2 + b)), 16'h0);
                chk("R6 irq on cause", {31'b0, irq}, 32'((en >> b) & 1));
                bus_write(2'd1, 4'b0100, 32'(1 << (2 + b)) << 16);
                chk("R7 irq drops", {31'b0, irq}, 32'h0);
            end
        end
        bus_write(2'd2, 4'b1000, 32'h0);
        seq_pulse(16'h0008, 16'h0);
        bus_write(2'd2, 4'b1000, 32'h0800_0000);
        chk("R6 enable alone no change", {31'b0, irq}, 32'h0);
        seq_pulse(16'h0004, 16'h0);
        chk("R6 re-evaluated", {31'b0, irq}, 32'h1);
        bus_write(2'd1, 4'b0100, 32'h000C_0000);
        chk("R7 cleared", {31'b0, irq}, 32'h0);

        // R11: sequencer reaches read-only bits; fetch completion raises irq
        seq_pulse(16'h0002, 16'h0);
        bus_write(2'd1, 4'b0100, 32'h0002_0000);
        bus_read(2'd1, 4'b0100, rd); chk("R11 RO bit set by sequencer", rd[17], 1'b1);
        seq_pulse(16'h0, 16'h0002);
        bus_read(2'd1, 4'b0100, rd); chk("R11 RO bit cleared by sequencer", rd[17], 1'b0);
        seq_pulse(16'h0008, 16'h0);
        chk("R11 completion irq", {31'b0, irq}, 32'h1);
        bus_write(2'd1, 4'b0100, 32'h0008_0000);
        chk("R11 completion cleared", {31'b0, irq}, 32'h0);

        // R10: control sweep with run transitions
        for (int v = 0; v < 256; v++) begin
            logic [7:0] nv;
            logic       rise, fall;
            if (v[1]) continue;
            nv = 8'(v) & 8'h1D;
            rise = nv[0] & ~exp_ctrl[0];
            fall = ~nv[0] & exp_ctrl[0];
            bus_write(2'd2, 4'b1000, 32'(v) << 24);
            if (rise) exp_sts[0] = 1'b0;
            if (fall) exp_sts[0] = 1'b1;
            exp_ctrl = nv;
            chk("R10 fetch_req pulse", {31'b0, fetch_req}, {31'b0, rise});
            chk("R10 halted", {31'b0, halted}, {31'b0, exp_sts[0]});
            @(negedge clk);
            chk("R10 fetch_req one cycle", {31'b0, fetch_req}, 32'h0);
            bus_read(2'd2, 4'b1000, rd); chk("R10 control masked", rd, {exp_ctrl, 24'h0});
        end

        // R12: stream reset while running
        bus_write(2'd0, 4'hF, 32'hCAFE_BAB4);
        bus_write(2'd1, 4'b0010, 32'h0000_0900);
        @(negedge clk);
        seq_load = 1'b1; seq_civ = 5'd3; seq_piv = 5'd4; seq_cnt = 16'h0077;
        @(negedge clk);
        seq_load = 1'b0;
        chk("R12 precondition run", {31'b0, run}, 32'h1);
        bus_write(2'd2, 4'b1000, 32'h0300_0000);
        exp_sts[0] = 1'b1;
        chk("R12 base cleared", base_addr, 32'h0);
        chk("R12 bd_valid cleared", {31'b0, bd_valid}, 32'h0);
        chk("R12 run cleared", {31'b0, run}, 32'h0);
        chk("R12 halted", {31'b0, halted}, 32'h1);
        bus_read(2'd1, 4'hF, rd); chk("R12 word1", rd, {exp_sts, 16'h0});
        bus_read(2'd2, 4'hF, rd); chk("R12 word2", rd, {exp_ctrl & 8'h1C, 24'h0});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule